// File: doc/BRIEF.md
# DAC Sample Release Pacer

This block decides the clock cycle in which a new 12-bit code is written into the DAC output register. In direct mode the code comes from a software write port. In the other three modes it comes from an upstream sample source (step generator, buffer FIFO or external-data path) through a valid/pop handshake. A release is allowed only after a programmable minimum number of DAC clock cycles has passed since the previous update. Between updates the output register keeps its value.

Releases in the source-fed modes are gated by a trigger. The trigger is a software trigger bit, optionally ORed with a hardware trigger input. In single-shot mode, each trigger event releases one sample. A software trigger bit clears itself once it has been used. An event that arrives while the spacing interval is still running is held, and only one event is held at a time. In continuous mode, samples are released on every permitted cycle while the trigger level is high. When the hardware input is marked synchronous, it is used directly, and every high cycle counts as an event. When it is marked asynchronous, it first passes through a synchronizer chain. After that, a rising edge counts as an event in single-shot mode, and the level is used in continuous mode. If a release is requested while the source is empty, a sticky empty flag is set.

A three-state controller tracks the trigger: ST_IDLE (nothing held), ST_PEND (one single-shot event held until the interval ends) and ST_RUN (continuous level active). The transitions are:
- ST_IDLE to ST_PEND: a single-shot event meets a running interval.
- ST_IDLE to ST_RUN: the continuous level is high.
- ST_PEND to ST_IDLE: the held event is serviced when the interval ends, or the mode changes.
- ST_RUN to ST_IDLE: the level drops, or the mode changes.

Top module: `dac_pacer`

## Requirements
- R1: After reset, dac_out is 0, dac_upd is 0, empty_flag is 0 and sw_trig_q is 0.
- R2: With cfg_mode = 2'b00 (direct), direct_wr while the interval has elapsed loads direct_data into dac_out one cycle later, and dac_upd is high in that cycle. A direct_wr made while the interval is running is ignored.
- R3: Two successive updates are separated by at least max(cfg_interval, 1) clock cycles.
- R4: In single-shot mode (cfg_cont = 0, cfg_mode not 2'b00), each trigger event releases exactly one sample. In the release cycle, src_pop is high and src_data is taken into dac_out.
- R5: A software trigger bit set in single-shot mode clears itself one cycle after it is set. In continuous mode it keeps the value last written.
- R6: A single-shot event that arrives during the interval is held and released in the first cycle the interval allows. A further event that arrives while one is held is dropped.
- R7: In continuous mode, a sample is released on every permitted cycle while the trigger level is high and src_valid is high. Releases stop in the cycle after the level goes low.
- R8: With cfg_hw_en = 1 and cfg_sync = 1, each cycle in which hw_trig_in is high is a trigger event, with no synchronizer delay.
- R9: With cfg_hw_en = 1 and cfg_sync = 0, hw_trig_in passes through SYNC_STAGES flops. A high level of any length gives one release in single-shot mode and gives releases for as long as the level lasts in continuous mode.
- R10: With cfg_hw_en = 0, hw_trig_in has no effect on releases.
- R11: A release request made while src_valid is low pops nothing, leaves dac_out unchanged and sets empty_flag. empty_flag stays set until an empty_clr strobe.
- R12: dac_out changes only in a cycle in which dac_upd is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DAC clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | 00 direct, 01 step, 10 buffer, 11 external data |
| cfg_cont | input | 1 | 1 continuous trigger, 0 single-shot |
| cfg_sync | input | 1 | 1 hardware trigger synchronous pulse, 0 asynchronous level |
| cfg_hw_en | input | 1 | Hardware trigger enable |
| cfg_interval | input | CNT_W | Minimum cycles between updates |
| sw_trig_wr | input | 1 | Write strobe for the software trigger bit |
| sw_trig_wdata | input | 1 | Value written to the software trigger bit |
| sw_trig_q | output | 1 | Current software trigger bit |
| hw_trig_in | input | 1 | Hardware trigger input |
| direct_wr | input | 1 | Direct-mode data write strobe |
| direct_data | input | DATA_W | Direct-mode data |
| src_valid | input | 1 | Sample source has data |
| src_data | input | DATA_W | Sample source head data |
| src_pop | output | 1 | Sample consumed this cycle |
| empty_clr | input | 1 | Clear strobe for the empty flag |
| empty_flag | output | 1 | Sticky flag: release requested while source was empty |
| dac_out | output | DATA_W | DAC output register |
| dac_upd | output | 1 | Pulse in the cycle dac_out takes a new value |

## Verification
The bench uses the defaults: DATA_W = 12, CNT_W = 16 and SYNC_STAGES = 2. It programs small intervals of 1, 3, 4 and 6, so that ignored direct writes, a held single-shot event and a dropped second event all fall inside short windows. The 16-bit counter is still the full width. The two-stage synchronizer makes the asynchronous release land exactly three edges after the input rises. That fixed latency lets the bench predict both the first release and the total release count for a level that lasts six cycles.

// File: rtl/dac_pacer_pkg.sv
package dac_pacer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_RUN  = 2'd2
    } pace_state_e;

    typedef enum logic [1:0] {
        MODE_DIRECT  = 2'b00,
        MODE_STEP    = 2'b01,
        MODE_BUFFER  = 2'b10,
        MODE_EXTDATA = 2'b11
    } pace_mode_e;

endpackage

// File: rtl/dac_pacer_trig.sv
module dac_pacer_trig #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_cont,
    input  logic cfg_sync,
    input  logic cfg_hw_en,
    input  logic sw_wr,
    input  logic sw_wdata,
    input  logic hw_in,
    output logic sw_q,
    output logic trig_evt,
    output logic trig_lvl
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic hw_s, hw_s_d;
    logic hw_evt, hw_lvl;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= hw_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[SYNC_STAGES-2:0], hw_in};
            end
        end
    endgenerate

    assign hw_s = chain_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hw_s_d <= 1'b0;
            sw_q   <= 1'b0;
        end else begin
            hw_s_d <= hw_s;
            if (sw_wr)
                sw_q <= sw_wdata;
            else if (!cfg_cont && sw_q)
                sw_q <= 1'b0;          // consumed as a single-shot event
        end
    end

    assign hw_evt   = cfg_hw_en & (cfg_sync ? hw_in : (hw_s & ~hw_s_d));
    assign hw_lvl   = cfg_hw_en & (cfg_sync ? hw_in : hw_s);
    assign trig_evt = ~cfg_cont & (sw_q | hw_evt);
    assign trig_lvl =  cfg_cont & (sw_q | hw_lvl);

    AST_SW_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_q && !cfg_cont && !sw_wr) |=> !sw_q); // R5

endmodule

// File: rtl/dac_pacer_rate.sv
module dac_pacer_rate #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] interval,
    input  logic             load,
    output logic             ready
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= (interval == '0) ? '0 : interval - CNT_W'(1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign ready = (cnt_q == '0);

endmodule

// File: rtl/dac_pacer.sv
module dac_pacer
    import dac_pacer_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_cont,
    input  logic              cfg_sync,
    input  logic              cfg_hw_en,
    input  logic [CNT_W-1:0]  cfg_interval,
    input  logic              sw_trig_wr,
    input  logic              sw_trig_wdata,
    output logic              sw_trig_q,
    input  logic              hw_trig_in,
    input  logic              direct_wr,
    input  logic [DATA_W-1:0] direct_data,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_pop,
    input  logic              empty_clr,
    output logic              empty_flag,
    output logic [DATA_W-1:0] dac_out,
    output logic              dac_upd
);
    pace_state_e state_q, state_d;
    logic trig_evt, trig_lvl, rate_ready;
    logic is_direct, req, fire, take, starve, load;

    dac_pacer_trig #(.SYNC_STAGES(SYNC_STAGES)) trig_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_cont(cfg_cont), .cfg_sync(cfg_sync), .cfg_hw_en(cfg_hw_en),
        .sw_wr(sw_trig_wr), .sw_wdata(sw_trig_wdata), .hw_in(hw_trig_in),
        .sw_q(sw_trig_q), .trig_evt(trig_evt), .trig_lvl(trig_lvl)
    );

    dac_pacer_rate #(.CNT_W(CNT_W)) rate_i (
        .clk(clk), .rst_n(rst_n),
        .interval(cfg_interval), .load(load), .ready(rate_ready)
    );

    assign is_direct = (cfg_mode == MODE_DIRECT);

    always_comb begin
        if (is_direct)     req = direct_wr;
        else if (cfg_cont) req = trig_lvl;
        else               req = trig_evt | (state_q == ST_PEND);
    end

    assign fire    = rate_ready & req;
    assign take    = fire & ~is_direct & src_valid;
    assign starve  = fire & ~is_direct & ~src_valid;
    assign load    = take | (fire & is_direct);
    assign src_pop = take;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!is_direct && !cfg_cont && trig_evt && !rate_ready)
                    state_d = ST_PEND;
                else if (!is_direct && cfg_cont && trig_lvl)
                    state_d = ST_RUN;
            end
            ST_PEND: begin
                if (is_direct || cfg_cont || rate_ready)
                    state_d = ST_IDLE;
            end
            ST_RUN: begin
                if (is_direct || !cfg_cont || !trig_lvl)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_out    <= '0;
            dac_upd    <= 1'b0;
            empty_flag <= 1'b0;
        end else begin
            dac_upd <= 1'b0;
            if (fire && is_direct) begin
                dac_out <= direct_data;
                dac_upd <= 1'b1;
            end else if (take) begin
                dac_out <= src_data;
                dac_upd <= 1'b1;
            end
            if (starve)         empty_flag <= 1'b1;
            else if (empty_clr) empty_flag <= 1'b0;
        end
    end

    // spacing monitor, independent of the rate counter
    logic [CNT_W-1:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             gap_q <= '1;
        else if (load)          gap_q <= CNT_W'(1);
        else if (gap_q != '1)   gap_q <= gap_q + CNT_W'(1);
    end

    AST_MIN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (gap_q >= cfg_interval)); // R3
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_out) |-> dac_upd); // R12
    AST_POP_UPDATES: assert property (@(posedge clk) disable iff (!rst_n)
        src_pop |=> (dac_upd && dac_out == $past(src_data))); // R4
    AST_EMPTY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_flag && !empty_clr) |=> empty_flag); // R11
    AST_PEND_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND && rate_ready && !cfg_cont && !is_direct && src_valid) |=> dac_upd); // R6

endmodule

// File: tb/dac_pacer_tb.sv
module dac_pacer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic        cfg_cont = 1'b0, cfg_sync = 1'b0, cfg_hw_en = 1'b0;
    logic [15:0] cfg_interval = 16'd0;
    logic        sw_trig_wr = 1'b0, sw_trig_wdata = 1'b0, sw_trig_q;
    logic        hw_trig_in = 1'b0, direct_wr = 1'b0;
    logic [11:0] direct_data = '0, src_data = '0, dac_out;
    logic        src_valid = 1'b0, src_pop, empty_clr = 1'b0, empty_flag, dac_upd;

    int n_chk = 0, n_fail = 0, n_upd = 0, base = 0, cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dac_pacer dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_cont(cfg_cont),
        .cfg_sync(cfg_sync), .cfg_hw_en(cfg_hw_en), .cfg_interval(cfg_interval),
        .sw_trig_wr(sw_trig_wr), .sw_trig_wdata(sw_trig_wdata), .sw_trig_q(sw_trig_q),
        .hw_trig_in(hw_trig_in), .direct_wr(direct_wr), .direct_data(direct_data),
        .src_valid(src_valid), .src_data(src_data), .src_pop(src_pop),
        .empty_clr(empty_clr), .empty_flag(empty_flag), .dac_out(dac_out), .dac_upd(dac_upd)
    );

    always @(negedge clk) if (rst_n && dac_upd) n_upd++;

    // direct-mode vectors: {wr, data, expected dac_out, expected dac_upd}, interval 3
    localparam logic [25:0] VEC [8] = '{
        {1'b1, 12'h111, 12'h111, 1'b1},
        {1'b1, 12'h222, 12'h111, 1'b0},
        {1'b1, 12'h333, 12'h111, 1'b0},
        {1'b1, 12'h444, 12'h444, 1'b1},
        {1'b0, 12'h000, 12'h444, 1'b0},
        {1'b0, 12'h000, 12'h444, 1'b0},
        {1'b0, 12'h000, 12'h444, 1'b0},
        {1'b1, 12'h555, 12'h555, 1'b1}
    };

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        chk("R1 dac_out", dac_out, 0);
        chk("R1 dac_upd", dac_upd, 0);
        rst_n = 1'b1;
        tick();
        chk("R1 empty_flag", empty_flag, 0);
        chk("R1 sw_trig_q", sw_trig_q, 0);

        // direct mode vector walk (R2, R3)
        cfg_interval = 16'd3;
        idle(2);
        for (int i = 0; i < 8; i++) begin
            direct_wr   = VEC[i][25];
            direct_data = VEC[i][24:13];
            tick();
            chk($sformatf("R2 vec%0d dac_out", i), dac_out, VEC[i][12:1]);
            chk($sformatf("R3 vec%0d dac_upd", i), dac_upd, VEC[i][0]);
        end
        direct_wr = 1'b0;

        // single-shot software trigger (R4, R5)
        cfg_mode = 2'b10; cfg_interval = 16'd4; src_valid = 1'b1; src_data = 12'hABC;
        idle(6);
        base = n_upd;
        sw_trig_wr = 1'b1; sw_trig_wdata = 1'b1; tick();
        sw_trig_wr = 1'b0;
        chk("R5 sw bit set", sw_trig_q, 1);
        chk("R4 no release yet", dac_upd, 0);
        tick();
        chk("R4 release", dac_upd, 1);
        chk("R4 data", dac_out, 12'hABC);
        chk("R5 self clear", sw_trig_q, 0);
        idle(8);
        chk("R4 one release", n_upd - base, 1);

        // held event during interval (R6, R3, R12)
        cfg_interval = 16'd6; src_data = 12'h123;
        idle(8);
        base = n_upd;
        sw_trig_wr = 1'b1; tick();
        sw_trig_wr = 1'b0; tick();
        chk("R6 first release", dac_out, 12'h123);
        src_data = 12'h456;
        sw_trig_wr = 1'b1; tick();
        sw_trig_wr = 1'b0; tick();
        sw_trig_wr = 1'b1; tick();
        sw_trig_wr = 1'b0; tick();
        tick();
        chk("R3 still spacing", dac_upd, 0);
        chk("R12 hold", dac_out, 12'h123);
        tick();
        chk("R6 held released", dac_upd, 1);
        chk("R6 held data", dac_out, 12'h456);
        idle(12);
        chk("R6 second dropped", n_upd - base, 2);

        // empty source (R11)
        cfg_interval = 16'd1; src_valid = 1'b0;
        idle(3);
        sw_trig_wr = 1'b1; tick();
        sw_trig_wr = 1'b0; tick();
        chk("R11 flag set", empty_flag, 1);
        chk("R11 no update", dac_upd, 0);
        chk("R11 out held", dac_out, 12'h456);
        tick();
        chk("R11 sticky", empty_flag, 1);
        empty_clr = 1'b1; tick();
        empty_clr = 1'b0;
        chk("R11 cleared", empty_flag, 0);
        src_valid = 1'b1;

        // continuous software level (R7, R5)
        cfg_cont = 1'b1; src_data = 12'h7A5;
        idle(2);
        base = n_upd;
        sw_trig_wr = 1'b1; sw_trig_wdata = 1'b1; tick();
        sw_trig_wr = 1'b0;
        chk("R5 cont set", sw_trig_q, 1);
        for (int k = 0; k < 5; k++) begin
            tick();
            chk("R7 each cycle", dac_upd, 1);
        end
        chk("R5 level kept", sw_trig_q, 1);
        sw_trig_wr = 1'b1; sw_trig_wdata = 1'b0; tick();
        sw_trig_wr = 1'b0;
        chk("R7 last release", dac_upd, 1);
        tick();
        chk("R7 stopped", dac_upd, 0);
        chk("R7 count", n_upd - base, 6);

        // synchronous hardware pulse (R8)
        cfg_cont = 1'b0; cfg_sync = 1'b1; cfg_hw_en = 1'b1; src_data = 12'h321;
        idle(2);
        base = n_upd;
        hw_trig_in = 1'b1; tick();
        hw_trig_in = 1'b0;
        chk("R8 immediate", dac_upd, 1);
        chk("R8 data", dac_out, 12'h321);
        tick();
        chk("R8 single", dac_upd, 0);
        hw_trig_in = 1'b1; idle(3);
        hw_trig_in = 1'b0; idle(3);
        chk("R8 per-cycle events", n_upd - base, 4);

        // hardware disabled (R10)
        cfg_hw_en = 1'b0; src_data = 12'h0F0;
        base = n_upd;
        hw_trig_in = 1'b1; idle(4);
        hw_trig_in = 1'b0; idle(2);
        chk("R10 no release", n_upd - base, 0);
        chk("R10 out held", dac_out, 12'h321);

        // asynchronous hardware, single-shot (R9)
        cfg_sync = 1'b0; cfg_hw_en = 1'b1; src_data = 12'h5A5;
        idle(4);
        base = n_upd;
        hw_trig_in = 1'b1; tick(); tick();
        chk("R9 sync delay", dac_upd, 0);
        tick();
        chk("R9 release", dac_upd, 1);
        chk("R9 data", dac_out, 12'h5A5);
        idle(6);
        hw_trig_in = 1'b0; idle(5);
        chk("R9 one per level", n_upd - base, 1);

        // asynchronous hardware, continuous (R9, R7)
        cfg_cont = 1'b1;
        base = n_upd;
        hw_trig_in = 1'b1; idle(6);
        hw_trig_in = 1'b0; idle(6);
        chk("R9 cont count", n_upd - base, 6);
        chk("R7 idle after", dac_upd, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule